// File: doc/BRIEF.md
# Strobe-Qualified Peripheral Register Slave

This block sits on the peripheral side of a 16-bit processor bus. The bus has a select line and an address-qualify line, both active low. It also has two independent byte strobes, one for the upper byte and one for the lower byte, a direction line, and a shared tri-state data bus. While select and address-qualify are both low, the block captures a 4-bit register index. It then serves one read or one write against a file of sixteen 16-bit registers. An active-low `hold_n` output tells the master when data is ready or has been taken.

The master sets the length of each transfer by how long it keeps its byte strobes low, not by a fixed count. Reads are recognised on a rising clock edge. Read data goes onto the bus from the following falling edge and is removed as soon as the strobes rise. Writes are recognised on a falling edge, and bus data is captured into the register on the next falling edge. Each byte lane follows its own strobe. The bus carries no valid/ready stream, so every pin is a plain control or data pin. The only back-pressure is `hold_n`: the master must keep its strobes low at least until `hold_n` has returned high.

Top module: `sbus_slave`

## Requirements
- R1: After reset every register holds 0, `dbus` is released (high impedance) and `hold_n` is 1.
- R2: The register index on `reg_addr` is captured on the first rising edge at which `sel_n` and `astb_n` are both 0. Later changes of `reg_addr` within that cycle have no effect.
- R3: With `rd_wr`=1 (1 = read), a read is recognised at the next rising edge on which either byte strobe is 0. `hold_n` is 0 for exactly one clock from that edge, and the register contents are driven from the falling edge inside that clock.
- R4: Read data stays driven for as long as the strobes are held low, including stretches of several clocks. The bus is released as soon as both strobes are 1.
- R5: With `rd_wr`=0, a write is recognised at a falling edge where a strobe is 0. `hold_n` goes 0 at the next rising edge for exactly one clock. Bus data is stored at the falling edge within that clock.
- R6: `ub_stb_n` governs bits 15:8 and `lb_stb_n` governs bits 7:0. A write changes only the lanes whose strobe is 0 at the capture edge. A read drives only the lanes whose strobe is 0 and leaves the other lanes released.
- R7: If `sel_n` or `astb_n` goes to 1 before the transfer completes, the cycle is aborted. The state returns to idle, `hold_n` is 1, the bus is released and no register changes.
- R8: `dbus` is never driven outside the drive window of a read, including throughout every write.
- R9: After a transfer has completed, further strobe activity is ignored until `sel_n` or `astb_n` has gone high and a new address phase begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select |
| astb_n | input | 1 | Active-low address qualify |
| rd_wr | input | 1 | 1 = read, 0 = write |
| ub_stb_n | input | 1 | Active-low strobe for bits 15:8 |
| lb_stb_n | input | 1 | Active-low strobe for bits 7:0 |
| reg_addr | input | 4 | Register index |
| dbus | inout | 16 | Tri-state data bus |
| hold_n | output | 1 | Active low while data is not yet valid or taken |

## Verification
Two functions can meet in a single clock: the falling-edge launch of read data and the release of the strobes. They also meet when an abort lands on the clock in which `hold_n` is low. The bench raises `astb_n` in the `hold_n`-low window of a read, then releases the strobes one cycle into the drive window. It judges from the pins that the bus lets go in the same half-cycle and that `hold_n` is back to 1 at the next rising edge. A write whose select is withdrawn before the strobes land is then read back to confirm that the register is unchanged.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_RD_WAIT,
    ST_RD_DRIVE,
    ST_WR_WAIT,
    ST_WR_HOLD,
    ST_DONE
  } sbus_state_e;
endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile
  import sbus_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [DW/LANE_W-1:0] wmask,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic                 cap,
  output logic [DW-1:0]        rdat
);
  localparam int DEPTH = 1 << AW;
  localparam int NL    = DW / LANE_W;

  logic [DW-1:0] mem [DEPTH];

  // storage updates on the falling edge (write data latch point)
  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    for (genvar l = 0; l < NL; l++) begin : g_lane
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
          mem[r][l*LANE_W +: LANE_W] <= '0;
        else if (we && wmask[l] && (addr == AW'(r)))
          mem[r][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  // read capture also on the falling edge so data is valid mid-cycle
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)   rdat <= '0;
    else if (cap) rdat <= mem[addr];
  end
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int AW = 4,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          astb_n,
  input  logic          rd_wr,
  input  logic [NL-1:0] stb_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q,
  output logic          rd_phase,
  output logic          rd_live,
  output logic          cap,
  output logic          we,
  output logic          hold_n
);
  sbus_state_e state, nxt;
  logic bus_sel, any_stb, wr_req;

  assign bus_sel = !sel_n && !astb_n;
  assign any_stb = !(&stb_n);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:     if (bus_sel) nxt = ST_ARMED;
      ST_ARMED:    if (!bus_sel)              nxt = ST_IDLE;
                   else if (wr_req)           nxt = ST_WR_WAIT;
                   else if (rd_wr && any_stb) nxt = ST_RD_WAIT;
      ST_RD_WAIT:  nxt = bus_sel ? ST_RD_DRIVE : ST_IDLE;
      ST_RD_DRIVE: if (!bus_sel)     nxt = ST_IDLE;
                   else if (!any_stb) nxt = ST_DONE;
      ST_WR_WAIT:  nxt = bus_sel ? ST_WR_HOLD : ST_IDLE;
      ST_WR_HOLD:  if (!bus_sel)     nxt = ST_IDLE;
                   else if (!any_stb) nxt = ST_DONE;
      ST_DONE:     if (!bus_sel) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && bus_sel) addr_q <= addr_in;
    end
  end

  // falling-edge side: write recognition and read launch
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_req  <= 1'b0;
      rd_live <= 1'b0;
    end else begin
      wr_req  <= (state == ST_ARMED) && !rd_wr && any_stb && bus_sel;
      rd_live <= (state == ST_RD_WAIT) || (state == ST_RD_DRIVE && rd_live);
    end
  end

  assign rd_phase = (state == ST_RD_WAIT) || (state == ST_RD_DRIVE);
  assign cap      = (state == ST_RD_WAIT);
  assign we       = (state == ST_WR_WAIT) && bus_sel;
  assign hold_n   = !((state == ST_RD_WAIT) || (state == ST_WR_WAIT));

  assert_hold_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> hold_n);
  assert_rd_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_WAIT) |-> ($past(state) == ST_ARMED));
  assert_wr_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR_WAIT) |-> (!$past(rd_wr) && $past(state) == ST_ARMED));
endmodule

// File: rtl/sbus_lane_ctl.sv
module sbus_lane_ctl #(
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_phase,
  input  logic          rd_live,
  input  logic          sel_n,
  input  logic          astb_n,
  input  logic          rd_wr,
  input  logic [NL-1:0] stb_n,
  output logic [NL-1:0] lane_en
);
  for (genvar l = 0; l < NL; l++) begin : g_en
    assign lane_en[l] = rd_phase && rd_live && !sel_n && !astb_n && !stb_n[l];
  end

  assert_no_drive_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_en) |-> rd_wr);
endmodule

// File: rtl/sbus_slave.sv
module sbus_slave
  import sbus_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          astb_n,
  input  logic          rd_wr,
  input  logic          ub_stb_n,
  input  logic          lb_stb_n,
  input  logic [AW-1:0] reg_addr,
  inout  wire  [DW-1:0] dbus,
  output logic          hold_n
);
  localparam int NL = DW / LANE_W;

  logic [NL-1:0] stb_n, lane_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdat;
  logic rd_phase, rd_live, cap, we;

  assign stb_n = {ub_stb_n, lb_stb_n};

  sbus_ctrl #(.AW(AW), .NL(NL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .astb_n(astb_n), .rd_wr(rd_wr),
    .stb_n(stb_n), .addr_in(reg_addr), .addr_q(addr_q), .rd_phase(rd_phase),
    .rd_live(rd_live), .cap(cap), .we(we), .hold_n(hold_n)
  );

  sbus_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .wmask(~stb_n), .addr(addr_q),
    .wdata(dbus), .cap(cap), .rdat(rdat)
  );

  sbus_lane_ctl #(.NL(NL)) u_lanes (
    .clk(clk), .rst_n(rst_n), .rd_phase(rd_phase), .rd_live(rd_live),
    .sel_n(sel_n), .astb_n(astb_n), .rd_wr(rd_wr), .stb_n(stb_n),
    .lane_en(lane_en)
  );

  for (genvar l = 0; l < NL; l++) begin : g_drv
    assign dbus[l*LANE_W +: LANE_W] = lane_en[l] ? rdat[l*LANE_W +: LANE_W] : {LANE_W{1'bz}};
  end

  assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || astb_n) |=> (hold_n && lane_en == '0));
endmodule

// File: tb/tb_sbus_slave.sv
module tb_sbus_slave;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, astb_n = 1'b1, rd_wr = 1'b1, ub = 1'b1, lb = 1'b1;
  logic [3:0] addr = '0;
  logic tb_oe = 1'b0;
  logic [15:0] tb_dat = '0;
  logic hold_n;
  wire [15:0] dbus;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] model [16];

  for (genvar g = 0; g < 16; g++) begin : g_pu
    pullup (dbus[g]);
  end
  assign dbus = tb_oe ? tb_dat : 16'hzzzz;

  sbus_slave dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .astb_n(astb_n), .rd_wr(rd_wr),
    .ub_stb_n(ub), .lb_stb_n(lb), .reg_addr(addr), .dbus(dbus), .hold_n(hold_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lane_view(input logic [15:0] v, input bit uh, input bit ul);
    return {uh ? v[15:8] : 8'hFF, ul ? v[7:0] : 8'hFF};
  endfunction

  task automatic end_cycle();
    @(posedge clk); #2 sel_n = 1; astb_n = 1; tb_oe = 0;
    @(posedge clk); #2;
  endtask

  // write with per-lane enables and a strobe stretch of n extra clocks (R5, R6, R8)
  task automatic do_write(input logic [3:0] a, input logic [15:0] d, input bit uh, input bit ul, input int n);
    @(posedge clk); #2 sel_n = 0; astb_n = 0; addr = a; rd_wr = 0;
    @(posedge clk); #1 chk(dbus == 16'hFFFF, "R8 bus free before write data", dbus, 16'hFFFF);
    #1 ub = !uh; lb = !ul; tb_oe = 1; tb_dat = d;
    @(posedge clk); #2 chk(hold_n == 0, "R5 hold low after write recognised", 16'(hold_n), 16'h0);
    @(posedge clk); #2 chk(hold_n == 1, "R5 hold high after latch", 16'(hold_n), 16'h1);
    repeat (n) @(posedge clk);
    #2 ub = 1; lb = 1;
    if (uh) model[a][15:8] = d[15:8];
    if (ul) model[a][7:0]  = d[7:0];
    end_cycle();
  endtask

  // read; new_a is presented on reg_addr after the address phase (R2)
  task automatic do_read(input logic [3:0] a, input logic [3:0] new_a, input bit uh, input bit ul, input int n);
    logic [15:0] exp;
    exp = lane_view(model[a], uh, ul);
    @(posedge clk); #2 sel_n = 0; astb_n = 0; addr = a; rd_wr = 1;
    @(posedge clk); #2 ub = !uh; lb = !ul; addr = new_a;
    @(posedge clk); #2 chk(hold_n == 0, "R3 hold low on read", 16'(hold_n), 16'h0);
    chk(dbus == 16'hFFFF, "R3 bus not yet driven", dbus, 16'hFFFF);
    #5 chk(dbus == exp, "R3 R6 R2 read data from falling edge", dbus, exp);
    @(posedge clk); #2 chk(hold_n == 1, "R3 hold released", 16'(hold_n), 16'h1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2 chk(dbus == exp, "R4 data held while strobe stretched", dbus, exp);
    end
    ub = 1; lb = 1;
    #1 chk(dbus == 16'hFFFF, "R4 bus released on strobe rise", dbus, 16'hFFFF);
    end_cycle();
  endtask

  task automatic t_reset();
    chk(hold_n == 1, "R1 hold high in reset", 16'(hold_n), 16'h1);
    chk(dbus == 16'hFFFF, "R1 bus released in reset", dbus, 16'hFFFF);
    do_read(4'd3, 4'd3, 1, 1, 0);
    do_read(4'd15, 4'd15, 1, 1, 0);
  endtask

  task automatic t_full();
    do_write(4'd1, 16'h1234, 1, 1, 0);
    do_write(4'd9, 16'hA5C3, 1, 1, 3);
    do_read(4'd1, 4'd1, 1, 1, 0);
    do_read(4'd9, 4'd9, 1, 1, 4);
  endtask

  task automatic t_bytes();
    do_write(4'd2, 16'h5566, 1, 1, 0);
    do_write(4'd2, 16'h7700, 1, 0, 1);
    do_write(4'd2, 16'h0011, 0, 1, 0);
    do_read(4'd2, 4'd2, 1, 1, 0);
    do_read(4'd2, 4'd2, 0, 1, 2);
    do_read(4'd2, 4'd2, 1, 0, 0);
  endtask

  task automatic t_addr_hold();
    do_write(4'd4, 16'h4444, 1, 1, 0);
    do_write(4'd5, 16'h5555, 1, 1, 0);
    do_read(4'd4, 4'd5, 1, 1, 1);
  endtask

  task automatic t_abort();
    // select withdrawn before the strobes of a write (R7)
    @(posedge clk); #2 sel_n = 0; astb_n = 0; addr = 4'd1; rd_wr = 0;
    @(posedge clk); #2 sel_n = 1; ub = 0; lb = 0; tb_oe = 1; tb_dat = 16'hDEAD;
    @(posedge clk); #2 chk(hold_n == 1, "R7 no hold after aborted write", 16'(hold_n), 16'h1);
    @(posedge clk); #2 chk(hold_n == 1, "R7 hold stays high", 16'(hold_n), 16'h1);
    ub = 1; lb = 1;
    end_cycle();
    do_read(4'd1, 4'd1, 1, 1, 0);
    // read aborted in its hold-low clock
    @(posedge clk); #2 sel_n = 0; astb_n = 0; addr = 4'd9; rd_wr = 1;
    @(posedge clk); #2 ub = 0; lb = 0;
    @(posedge clk); #2 chk(hold_n == 0, "R7 read recognised before abort", 16'(hold_n), 16'h0);
    astb_n = 1;
    #5 chk(dbus == 16'hFFFF, "R7 bus released on abort", dbus, 16'hFFFF);
    @(posedge clk); #2 chk(hold_n == 1, "R7 hold high after abort", 16'(hold_n), 16'h1);
    ub = 1; lb = 1;
    end_cycle();
  endtask

  task automatic t_ignore();
    do_write(4'd7, 16'h0707, 1, 1, 0);
    @(posedge clk); #2 sel_n = 0; astb_n = 0; addr = 4'd7; rd_wr = 0;
    @(posedge clk); #2 ub = 0; lb = 0; tb_oe = 1; tb_dat = 16'h1357;
    repeat (3) @(posedge clk);
    #2 ub = 1; lb = 1; tb_dat = 16'hBEEF;
    @(posedge clk); #2 ub = 0; lb = 0;
    @(posedge clk); #2 chk(hold_n == 1, "R9 repeat strobe ignored", 16'(hold_n), 16'h1);
    @(posedge clk); #2 ub = 1; lb = 1;
    model[7] = 16'h1357;
    end_cycle();
    do_read(4'd7, 4'd7, 1, 1, 0);
  endtask

  task automatic t_b2b();
    do_write(4'd10, 16'hC0DE, 1, 1, 0);
    do_write(4'd11, 16'h0B0B, 1, 1, 0);
    do_read(4'd10, 4'd10, 1, 1, 0);
    do_read(4'd11, 4'd11, 1, 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    #(CLK_PERIOD * 2 + 3);
    t_reset_pre: chk(hold_n == 1, "R1 hold high during reset", 16'(hold_n), 16'h1);
    rst_n = 1;
    t_reset();
    t_full();
    t_bytes();
    t_addr_hold();
    t_abort();
    t_ignore();
    t_b2b();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule